// File: doc/BRIEF.md
# Coalescing Transaction Tag Tracker

This block hands out tags for non-blocking memory transfers and keeps track of them. It holds a small pool of tags. Each issue request either asks for a fresh tag or names a tag it already holds. Naming a held tag merges the new transfer into that tag, so several transfers share one tag. Every accepted request goes out on a downstream request port together with its tag. Completion responses come back carrying the tag, and each one lowers that tag's count of outstanding transfers.

A requester asks about a tag through a test port, which answers at once, or through a wait port. On the wait port the requester keeps the request raised until the done flag appears. When either port reports success, the tag returns to the pool. A tag whose transfers have all finished stays allocated until that happens. If no tag can be given, the issue response carries the invalid code and the requester tries again later.

Top module: `txn_tag_tracker`

## Requirements
- R1: After reset every tag is free, no request is presented downstream, the issue response is the invalid code (all ones, 4'hF at default width), and test_done and wait_done are low.
- R2: An issue whose join field is the invalid code allocates the lowest-numbered free tag. The allocated tag is returned on issue_tag in the same cycle. The request appears on the mem_req outputs with that tag and with the issue address, length and direction.
- R3: When every tag is held, a fresh-tag issue returns the invalid code, raises neither mem_req_valid nor issue_err, and changes no state.
- R4: An issue whose join field names a held tag is merged into that tag. It returns the same tag and raises that tag's outstanding count by one.
- R5: An issue whose join field names a free tag, or a value that is neither a tag index nor the invalid code, returns the invalid code, raises issue_err and presents no downstream request.
- R6: A completion lowers the named tag's outstanding count by one. A completion for a free tag, or for a tag whose count is already zero, has no effect.
- R7: test_done is high in the cycle of a test only if the tag is held and its registered count is zero. A completion in the same cycle is not yet counted. A successful test frees the tag, and a failed test leaves it held.
- R8: wait_done stays low while the waited tag has outstanding transfers. It rises in the first cycle the registered count is zero, and the tag is freed at the end of that cycle.
- R9: A tag whose transfers have all completed stays allocated until a test or wait on it succeeds.
- R10: If an issue merges into a tag in the same cycle that a test or wait names it, the merge wins: the tag is returned, the query reports not done, and the tag stays held.
- R11: A merge into a tag whose count is at its maximum (2^CNT_W-1) returns the invalid code without issue_err, and the requester may retry it.
- R12: While mem_req_ready is low, an issue returns the invalid code and allocates or merges nothing. mem_req_valid still shows the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request present |
| issue_join_tag | input | TAG_W | Tag to merge into; invalid code asks for a new tag |
| issue_addr | input | ADDR_W | Memory address of the transfer |
| issue_len | input | LEN_W | Transfer length in bytes |
| issue_to_mem | input | 1 | Direction: 1 moves buffer data to memory |
| issue_tag | output | TAG_W | Tag granted this cycle, or the invalid code |
| issue_err | output | 1 | Join field named a tag that is not held |
| mem_req_valid | output | 1 | Downstream request present |
| mem_req_ready | input | 1 | Downstream accepts the request |
| mem_req_tag | output | TAG_W | Tag of the downstream request |
| mem_req_addr | output | ADDR_W | Address of the downstream request |
| mem_req_len | output | LEN_W | Length of the downstream request |
| mem_req_to_mem | output | 1 | Direction of the downstream request |
| cpl_valid | input | 1 | Completion response present |
| cpl_tag | input | TAG_W | Tag of the completed transfer |
| test_valid | input | 1 | Test request present |
| test_tag | input | TAG_W | Tag being tested |
| test_done | output | 1 | All transfers under the tested tag are complete |
| wait_valid | input | 1 | Wait request present, held until done |
| wait_tag | input | TAG_W | Tag being waited on |
| wait_done | output | 1 | Wait satisfied this cycle |

## Verification
Two pairs of events can land in the same cycle, and both depend on which of them is seen first. In the first pair, a completion that brings a count to zero arrives while a wait or test names the same tag. The bench raises both in one cycle and expects the done flag to stay low, then to rise in the following cycle. In the second pair, a merge into a finished tag arrives while a test names that tag. The bench expects the tag to be returned and the test to report not done, and afterwards checks that the tag still holds one outstanding transfer.

// File: rtl/txn_tag_pkg.sv
package txn_tag_pkg;

    typedef enum logic [1:0] {
        ISS_NONE = 2'd0,
        ISS_NEW  = 2'd1,
        ISS_JOIN = 2'd2
    } iss_kind_e;

endpackage

// File: rtl/tag_free_pick.sv
module tag_free_pick #(
    parameter int NUM_TAGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_TAGS-1:0] free_vec,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tag_issue_ctrl.sv
module tag_issue_ctrl
    import txn_tag_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int IDX_W    = 3,
    parameter int TAG_W    = 4
) (
    input  logic                issue_valid,
    input  logic [TAG_W-1:0]    join_tag,
    input  logic                mem_ready,
    input  logic [NUM_TAGS-1:0] held_vec,
    input  logic [NUM_TAGS-1:0] full_vec,
    input  logic                pick_found,
    input  logic [IDX_W-1:0]    pick_idx,
    output iss_kind_e           kind,
    output logic [IDX_W-1:0]    slot,
    output logic [TAG_W-1:0]    tag_out,
    output logic                req_valid,
    output logic                err
);

    localparam logic [TAG_W-1:0] INV_TAG = '1;
    localparam logic [TAG_W-1:0] LIMIT   = TAG_W'(NUM_TAGS);

    logic             want_new;
    logic             in_range;
    logic [IDX_W-1:0] jidx;
    logic             tgt_ok;

    always_comb begin
        want_new  = (join_tag == INV_TAG);
        in_range  = (join_tag < LIMIT);
        jidx      = join_tag[IDX_W-1:0];
        tgt_ok    = 1'b0;
        slot      = '0;
        err       = 1'b0;
        kind      = ISS_NONE;
        if (issue_valid) begin
            if (want_new) begin
                if (pick_found) begin
                    tgt_ok = 1'b1;
                    slot   = pick_idx;
                end
            end else if (in_range && held_vec[jidx]) begin
                slot = jidx;
                if (!full_vec[jidx]) begin
                    tgt_ok = 1'b1;
                end
            end else begin
                err = 1'b1;
            end
            if (tgt_ok && mem_ready) begin
                kind = want_new ? ISS_NEW : ISS_JOIN;
            end
        end
        req_valid = tgt_ok;
        tag_out   = (kind != ISS_NONE) ? {1'b0, slot} : INV_TAG;
    end

endmodule

// File: rtl/tag_slot.sv
module tag_slot #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc,
    input  logic join_in,
    input  logic dec,
    input  logic rel,
    output logic held,
    output logic zero,
    output logic full
);

    typedef struct packed {
        logic             held;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (alloc) begin
            st_d.held = 1'b1;
            st_d.cnt  = CNT_W'(1);
        end else if (st_q.held) begin
            st_d.cnt = st_q.cnt + CNT_W'(join_in) - CNT_W'(dec);
            if (rel) begin
                st_d.held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.held;
    assign zero = (st_q.cnt == '0);
    assign full = &st_q.cnt;

endmodule

// File: rtl/txn_tag_tracker.sv
module txn_tag_tracker
    import txn_tag_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int CNT_W    = 4,
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 12,
    parameter int IDX_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
    parameter int TAG_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [TAG_W-1:0]  issue_join_tag,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [LEN_W-1:0]  issue_len,
    input  logic              issue_to_mem,
    output logic [TAG_W-1:0]  issue_tag,
    output logic              issue_err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [TAG_W-1:0]  mem_req_tag,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LEN_W-1:0]  mem_req_len,
    output logic              mem_req_to_mem,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic              test_valid,
    input  logic [TAG_W-1:0]  test_tag,
    output logic              test_done,
    input  logic              wait_valid,
    input  logic [TAG_W-1:0]  wait_tag,
    output logic              wait_done
);

    logic [NUM_TAGS-1:0] tag_held;
    logic [NUM_TAGS-1:0] tag_zero;
    logic [NUM_TAGS-1:0] tag_full;
    logic [NUM_TAGS-1:0] alloc_vec, join_vec, dec_vec, rel_vec;
    logic [NUM_TAGS-1:0] qt_vec, qw_vec, ok_vec;

    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    iss_kind_e        kind;
    logic [IDX_W-1:0] slot;

    tag_free_pick #(.NUM_TAGS(NUM_TAGS), .IDX_W(IDX_W)) u_pick (
        .free_vec (~tag_held),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    tag_issue_ctrl #(.NUM_TAGS(NUM_TAGS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .issue_valid (issue_valid),
        .join_tag    (issue_join_tag),
        .mem_ready   (mem_req_ready),
        .held_vec    (tag_held),
        .full_vec    (tag_full),
        .pick_found  (pick_found),
        .pick_idx    (pick_idx),
        .kind        (kind),
        .slot        (slot),
        .tag_out     (issue_tag),
        .req_valid   (mem_req_valid),
        .err         (issue_err)
    );

    assign mem_req_tag    = {1'b0, slot};
    assign mem_req_addr   = issue_addr;
    assign mem_req_len    = issue_len;
    assign mem_req_to_mem = issue_to_mem;

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
        localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i);

        always_comb begin
            alloc_vec[i] = (kind == ISS_NEW)  && (slot == IDX_W'(i));
            join_vec[i]  = (kind == ISS_JOIN) && (slot == IDX_W'(i));
            dec_vec[i]   = cpl_valid && (cpl_tag == MY_TAG) && tag_held[i] && !tag_zero[i];
            qt_vec[i]    = test_valid && (test_tag == MY_TAG);
            qw_vec[i]    = wait_valid && (wait_tag == MY_TAG);
            ok_vec[i]    = tag_held[i] && tag_zero[i] && !join_vec[i];
            rel_vec[i]   = (qt_vec[i] || qw_vec[i]) && ok_vec[i];
        end

        tag_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (alloc_vec[i]),
            .join_in (join_vec[i]),
            .dec     (dec_vec[i]),
            .rel     (rel_vec[i]),
            .held    (tag_held[i]),
            .zero    (tag_zero[i]),
            .full    (tag_full[i])
        );
    end

    assign test_done = |(qt_vec & ok_vec);
    assign wait_done = |(qw_vec & ok_vec);

endmodule

// File: rtl/txn_tag_tracker_chk.sv
module txn_tag_tracker_chk #(
    parameter int NUM_TAGS = 8,
    parameter int IDX_W    = 3,
    parameter int TAG_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                issue_valid,
    input logic [TAG_W-1:0]    issue_tag,
    input logic                issue_err,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [TAG_W-1:0]    mem_req_tag,
    input logic                test_valid,
    input logic [TAG_W-1:0]    test_tag,
    input logic                test_done,
    input logic                wait_valid,
    input logic                wait_done,
    input logic [NUM_TAGS-1:0] tag_held
);

    localparam logic [TAG_W-1:0] INV_TAG = '1;

    a_r2_grant_goes_down: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_tag != INV_TAG) |-> (mem_req_valid && mem_req_ready && mem_req_tag == issue_tag));

    a_r5_err_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        issue_err |-> (!mem_req_valid && issue_tag == INV_TAG));

    a_r7_test_frees: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |=> !tag_held[$past(test_tag[IDX_W-1:0])]);

    a_r8_wait_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        wait_done |-> wait_valid);

    a_r9_no_silent_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_valid && !wait_valid) |=> ((tag_held & $past(tag_held)) == $past(tag_held)));

    a_r12_stall_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !mem_req_ready) |-> (issue_tag == INV_TAG));

endmodule

bind txn_tag_tracker txn_tag_tracker_chk #(
    .NUM_TAGS(NUM_TAGS), .IDX_W(IDX_W), .TAG_W(TAG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_tag     (issue_tag),
    .issue_err     (issue_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_tag   (mem_req_tag),
    .test_valid    (test_valid),
    .test_tag      (test_tag),
    .test_done     (test_done),
    .wait_valid    (wait_valid),
    .wait_done     (wait_done),
    .tag_held      (tag_held)
);

// File: tb/sim_txn_tag_tracker.sv
module sim_txn_tag_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int INV = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [3:0]  issue_join_tag;
    logic [31:0] issue_addr;
    logic [11:0] issue_len;
    logic        issue_to_mem;
    logic [3:0]  issue_tag;
    logic        issue_err;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [3:0]  mem_req_tag;
    logic [31:0] mem_req_addr;
    logic [11:0] mem_req_len;
    logic        mem_req_to_mem;
    logic        cpl_valid;
    logic [3:0]  cpl_tag;
    logic        test_valid;
    logic [3:0]  test_tag;
    logic        test_done;
    logic        wait_valid;
    logic [3:0]  wait_tag;
    logic        wait_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txn_tag_tracker u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        issue_valid    = 1'b0;
        issue_join_tag = 4'(INV);
        issue_addr     = '0;
        issue_len      = '0;
        issue_to_mem   = 1'b0;
        cpl_valid      = 1'b0;
        cpl_tag        = '0;
        test_valid     = 1'b0;
        test_tag       = '0;
        wait_valid     = 1'b0;
        wait_tag       = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        mem_req_ready = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input int jt, input int exp_tag, input int exp_err, input string req);
        issue_valid    = 1'b1;
        issue_join_tag = 4'(jt);
        issue_addr     = 32'h1000 + 32'(n_tests);
        issue_len      = 12'(8 + n_tests);
        issue_to_mem   = n_tests[0];
        #1;
        chk(req, "issue_tag", int'(issue_tag), exp_tag);
        chk(req, "issue_err", int'(issue_err), exp_err);
        if (exp_tag != INV) begin
            chk(req, "mem_req_tag", int'(mem_req_tag), exp_tag);
            chk(req, "mem_req_addr", int'(mem_req_addr == issue_addr), 1);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        issue_join_tag = 4'(INV);
    endtask

    task automatic cpl(input int t);
        cpl_valid = 1'b1;
        cpl_tag   = 4'(t);
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic tst(input int t, input int exp, input string req);
        test_valid = 1'b1;
        test_tag   = 4'(t);
        #1;
        chk(req, "test_done", int'(test_done), exp);
        @(negedge clk);
        test_valid = 1'b0;
    endtask

    task automatic sc_reset();
        do_reset();
        #1;
        chk("R1", "mem_req_valid", int'(mem_req_valid), 0);
        chk("R1", "issue_tag idle", int'(issue_tag), INV);
        chk("R1", "test_done", int'(test_done), 0);
        chk("R1", "wait_done", int'(wait_done), 0);
        issue(INV, 0, 0, "R1");
    endtask

    task automatic sc_alloc();
        do_reset();
        for (int i = 0; i < 3; i++) issue(INV, i, 0, "R2");
    endtask

    task automatic sc_join_test();
        do_reset();
        issue(INV, 0, 0, "R2");
        issue(0, 0, 0, "R4");
        tst(0, 0, "R7");
        cpl(0);
        tst(0, 0, "R7");
        cpl(0);
        tst(0, 1, "R7");
        issue(INV, 0, 0, "R7");
    endtask

    task automatic sc_hold();
        do_reset();
        issue(INV, 0, 0, "R2");
        cpl(0);
        issue(INV, 1, 0, "R9");
        tst(0, 1, "R9");
        issue(INV, 0, 0, "R9");
    endtask

    task automatic sc_full();
        do_reset();
        for (int i = 0; i < 8; i++) issue(INV, i, 0, "R2");
        issue_valid = 1'b1;
        issue_join_tag = 4'(INV);
        #1;
        chk("R3", "issue_tag full", int'(issue_tag), INV);
        chk("R3", "mem_req_valid full", int'(mem_req_valid), 0);
        chk("R3", "issue_err full", int'(issue_err), 0);
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic sc_badjoin();
        do_reset();
        issue_valid = 1'b1;
        issue_join_tag = 4'd3;
        #1;
        chk("R5", "issue_tag free join", int'(issue_tag), INV);
        chk("R5", "issue_err free join", int'(issue_err), 1);
        chk("R5", "mem_req_valid", int'(mem_req_valid), 0);
        @(negedge clk);
        issue_valid = 1'b0;
        issue(9, INV, 1, "R5");
        issue(INV, 0, 0, "R5");
    endtask

    task automatic sc_cpl_ignore();
        do_reset();
        issue(INV, 0, 0, "R2");
        cpl(0);
        cpl(0);
        cpl(5);
        tst(0, 1, "R6");
        issue(INV, 0, 0, "R6");
        tst(0, 0, "R6");
    endtask

    task automatic sc_wait();
        do_reset();
        issue(INV, 0, 0, "R2");
        wait_valid = 1'b1;
        wait_tag   = 4'd0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8", "wait_done pending", int'(wait_done), 0);
            @(negedge clk);
        end
        cpl_valid = 1'b1;
        cpl_tag   = 4'd0;
        #1;
        chk("R8", "wait_done same-cycle cpl", int'(wait_done), 0);
        @(negedge clk);
        cpl_valid = 1'b0;
        #1;
        chk("R8", "wait_done after cpl", int'(wait_done), 1);
        @(negedge clk);
        wait_valid = 1'b0;
        issue(INV, 0, 0, "R8");
    endtask

    task automatic sc_collide();
        do_reset();
        issue(INV, 0, 0, "R2");
        cpl(0);
        issue_valid    = 1'b1;
        issue_join_tag = 4'd0;
        test_valid     = 1'b1;
        test_tag       = 4'd0;
        #1;
        chk("R10", "issue_tag join", int'(issue_tag), 0);
        chk("R10", "test_done blocked", int'(test_done), 0);
        @(negedge clk);
        issue_valid = 1'b0;
        issue_join_tag = 4'(INV);
        test_valid = 1'b0;
        tst(0, 0, "R10");
        cpl(0);
        tst(0, 1, "R10");
    endtask

    task automatic sc_sat();
        do_reset();
        issue(INV, 0, 0, "R2");
        for (int i = 0; i < 14; i++) issue(0, 0, 0, "R11");
        issue(0, INV, 0, "R11");
        cpl(0);
        issue(0, 0, 0, "R11");
    endtask

    task automatic sc_ready();
        do_reset();
        mem_req_ready = 1'b0;
        issue_valid = 1'b1;
        issue_join_tag = 4'(INV);
        #1;
        chk("R12", "issue_tag stalled", int'(issue_tag), INV);
        chk("R12", "mem_req_valid stalled", int'(mem_req_valid), 1);
        @(negedge clk);
        issue_valid = 1'b0;
        mem_req_ready = 1'b1;
        issue(INV, 0, 0, "R12");
    endtask

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        mem_req_ready = 1'b1;
        sc_reset();
        sc_alloc();
        sc_join_test();
        sc_hold();
        sc_full();
        sc_badjoin();
        sc_cpl_ignore();
        sc_wait();
        sc_collide();
        sc_sat();
        sc_ready();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule